// File: doc/BRIEF.md
# Nibble-serial firmware bus target

This block is the memory-side target of a firmware bus that moves commands, addresses and data four bits at a time over a shared nibble bus, alongside one active-low framing line. The bus runs in step with a 33 MHz system clock at 3.3 V levels. The target decodes each bus cycle from the nibbles it samples. It keeps a cycle only when the device-select nibble matches its four strap inputs, so up to sixteen targets can share one bus. For each accepted cycle it raises one byte-wide request on a simple memory port that has a ready handshake.

A cycle starts with a start nibble, then a select nibble, seven address nibbles and a size nibble. A read then has a two-clock turnaround, a sync field, the data byte and a closing turnaround. A write carries its data byte right after the size nibble, then has a turnaround, a sync field and a closing turnaround. The target drives the bus only in its sync and read-data fields and on the first clock of the closing turnaround. Two protection inputs can veto memory writes. One covers the highest block of the array. The other covers every other block.

Top module: `fwb_target`

## Requirements
- R1: The framing line low together with nibble 4'b1101 starts a read and with 4'b1110 starts a write. Any other nibble while framing is low returns the target to idle, and it then neither drives the bus nor raises a request until the next valid start.
- R2: The nibble after the start must equal `strap_id`. On a mismatch the rest of the cycle is ignored: no bus drive and no memory request.
- R3: Seven address nibbles follow, most significant first. `mem_addr` carries the low MEM_AW bits of the assembled address, and higher address bits are ignored.
- R4: The size nibble must be 4'b0000 (one byte). Any other value abandons the cycle with no drive and no request.
- R5: Read: the target leaves the bus undriven for the two clocks after the size nibble. In the sync field it drives 4'b0101 while its request is outstanding and 4'b0000 for one clock once served. It then drives data bits [3:0] and bits [7:4], drives 4'b1111 for one clock, and releases the bus.
- R6: Write: the data byte arrives low nibble first, right after the size nibble. The two clocks after the data and the data clocks themselves are undriven by the target. Sync, the 4'b1111 clock and release follow as in R5. An unblocked write produces one memory write with the assembled address and the byte.
- R7: `mem_req` stays high with `mem_addr` and `mem_we` stable until `mem_ready` is sampled high. Each request that has to wait N cycles beyond its first (memory ready in the (N+1)-th request cycle) gives max(0, N-1) wait nibbles in sync.
- R8: With `top_lock` high when the last data nibble is sampled, a write whose address lies in the top block (address bits [MEM_AW-1:BLOCK_W] all ones) raises no request. The bus cycle still completes with an immediate ready code.
- R9: With `wr_protect` high, writes to every block except the top block are dropped in the same way. Top-block writes are unaffected by `wr_protect`.
- R10: The framing line going low at any point of a cycle aborts it and withdraws any outstanding request. A valid start nibble at that point begins a new cycle.
- R11: While reset is held and right after it, the bus is undriven and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Framing line, low marks a start nibble |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | High when the target drives the bus |
| strap_id | input | 4 | Device-select strap value |
| top_lock | input | 1 | Blocks writes to the top block |
| wr_protect | input | 1 | Blocks writes to all other blocks |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte from memory |
| mem_ready | input | 1 | Memory accepts or answers the request this cycle |

## Verification
A sequencer that drifts by one field shifts every later nibble. This shows at the ports within a clock or two, as a drive during a host-owned turnaround, a missing ready code or swapped data nibbles. A stuck or dropped request flag shows as a sync field that never ends or ends early, and as a memory write that is missing or extra after a protected access. A wrong address shift order shows only at the memory port, in the byte address of the request. The bench therefore compares those addresses and the read data nibble by nibble.

// File: rtl/fwb_pkg.sv
`timescale 1ns/1ps
package fwb_pkg;

    // Nibble codes on the shared bus
    localparam logic [3:0] CODE_RD_START = 4'b1101;
    localparam logic [3:0] CODE_WR_START = 4'b1110;
    localparam logic [3:0] CODE_SIZE_1B  = 4'b0000;
    localparam logic [3:0] CODE_SYNC_WT  = 4'b0101;
    localparam logic [3:0] CODE_SYNC_OK  = 4'b0000;
    localparam logic [3:0] CODE_ONES     = 4'b1111;

    // Field being presented on the bus in the current clock
    typedef enum logic [3:0] {
        S_IDLE,
        S_IDSEL,
        S_ADDR,
        S_SIZE,
        S_RTAR0,
        S_RTAR1,
        S_WD0,
        S_WD1,
        S_WTAR0,
        S_WTAR1,
        S_SYNC,
        S_RD0,
        S_RD1,
        S_ETAR0,
        S_ETAR1
    } fwb_state_e;

    // One-clock strobes from the sequencer to the datapath
    typedef struct packed {
        logic abort;
        logic shift_addr;
        logic cap_lo;
        logic cap_hi;
        logic issue_rd;
        logic issue_wr;
    } fwb_ctl_t;

    function automatic logic is_start(input logic [3:0] nib);
        return (nib == CODE_RD_START) || (nib == CODE_WR_START);
    endfunction

endpackage

// File: rtl/fwb_seq.sv
`timescale 1ns/1ps
module fwb_seq
    import fwb_pkg::*;
#(
    parameter int ADDR_NIBS = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic [3:0] bus_in,
    input  logic [3:0] strap_id,
    input  logic       pend,
    output fwb_state_e state,
    output fwb_ctl_t   ctl
);

    localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

    fwb_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             wr_q;
    logic             wr_d;

    always_comb begin
        nxt  = state;
        ctl  = '0;
        wr_d = wr_q;
        if (!frame_n) begin
            // framing low always (re)starts decoding
            ctl.abort = 1'b1;
            if (is_start(bus_in)) begin
                nxt  = S_IDSEL;
                wr_d = (bus_in == CODE_WR_START);
            end else begin
                nxt = S_IDLE;
            end
        end else begin
            case (state)
                S_IDLE:  nxt = S_IDLE;
                S_IDSEL: nxt = (bus_in == strap_id) ? S_ADDR : S_IDLE;
                S_ADDR: begin
                    ctl.shift_addr = 1'b1;
                    if (cnt == CNT_LAST) nxt = S_SIZE;
                end
                S_SIZE: begin
                    if (bus_in != CODE_SIZE_1B) begin
                        nxt = S_IDLE;
                    end else if (wr_q) begin
                        nxt = S_WD0;
                    end else begin
                        nxt          = S_RTAR0;
                        ctl.issue_rd = 1'b1;
                    end
                end
                S_RTAR0: nxt = S_RTAR1;
                S_RTAR1: nxt = S_SYNC;
                S_WD0: begin
                    ctl.cap_lo = 1'b1;
                    nxt        = S_WD1;
                end
                S_WD1: begin
                    ctl.cap_hi   = 1'b1;
                    ctl.issue_wr = 1'b1;
                    nxt          = S_WTAR0;
                end
                S_WTAR0: nxt = S_WTAR1;
                S_WTAR1: nxt = S_SYNC;
                S_SYNC: begin
                    if (!pend) nxt = wr_q ? S_ETAR0 : S_RD0;
                end
                S_RD0:   nxt = S_RD1;
                S_RD1:   nxt = S_ETAR0;
                S_ETAR0: nxt = S_ETAR1;
                S_ETAR1: nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            wr_q  <= 1'b0;
            cnt   <= '0;
        end else begin
            state <= nxt;
            wr_q  <= wr_d;
            cnt   <= (frame_n && state == S_ADDR) ? cnt + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/fwb_capture.sv
`timescale 1ns/1ps
module fwb_capture
    import fwb_pkg::*;
#(
    parameter int MEM_AW = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  fwb_ctl_t          ctl,
    input  logic [3:0]        bus_in,
    output logic [MEM_AW-1:0] addr,
    output logic [7:0]        wbyte
);

    // only the low MEM_AW bits survive the seven shifts
    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            wbyte <= '0;
        end else begin
            if (ctl.shift_addr) addr <= {addr[MEM_AW-5:0], bus_in};
            if (ctl.cap_lo)     wbyte[3:0] <= bus_in;
            if (ctl.cap_hi)     wbyte[7:4] <= bus_in;
        end
    end

endmodule

// File: rtl/fwb_memport.sv
`timescale 1ns/1ps
module fwb_memport
    import fwb_pkg::*;
#(
    parameter int MEM_AW  = 19,
    parameter int BLOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  fwb_ctl_t          ctl,
    input  logic [MEM_AW-1:0] addr,
    input  logic              top_lock,
    input  logic              wr_protect,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic              pend,
    output logic              mem_we,
    output logic [7:0]        rbyte
);

    logic in_top;
    logic blocked;

    assign in_top  = &addr[MEM_AW-1:BLOCK_W];
    assign blocked = in_top ? top_lock : wr_protect;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            mem_we <= 1'b0;
            rbyte  <= '0;
        end else if (ctl.abort) begin
            pend <= 1'b0;
        end else if (ctl.issue_rd) begin
            pend   <= 1'b1;
            mem_we <= 1'b0;
        end else if (ctl.issue_wr) begin
            pend   <= !blocked;
            mem_we <= 1'b1;
        end else if (pend && mem_ready) begin
            pend <= 1'b0;
            if (!mem_we) rbyte <= mem_rdata;
        end
    end

endmodule

// File: rtl/fwb_drive.sv
`timescale 1ns/1ps
module fwb_drive
    import fwb_pkg::*;
(
    input  fwb_state_e state,
    input  logic       pend,
    input  logic [7:0] rbyte,
    output logic [3:0] bus_out,
    output logic       bus_oe
);

    always_comb begin
        bus_oe  = 1'b1;
        bus_out = CODE_ONES;
        case (state)
            S_SYNC:  bus_out = pend ? CODE_SYNC_WT : CODE_SYNC_OK;
            S_RD0:   bus_out = rbyte[3:0];
            S_RD1:   bus_out = rbyte[7:4];
            S_ETAR0: bus_out = CODE_ONES;
            default: bus_oe  = 1'b0;
        endcase
    end

endmodule

// File: rtl/fwb_target.sv
`timescale 1ns/1ps
module fwb_target
    import fwb_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int MEM_AW    = 19,
    parameter int BLOCK_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        strap_id,
    input  logic              top_lock,
    input  logic              wr_protect,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);

    fwb_state_e  state;
    fwb_ctl_t    ctl;
    logic        pend;
    logic [7:0]  rbyte;

    fwb_seq #(.ADDR_NIBS(ADDR_NIBS)) u_seq (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in),
        .strap_id(strap_id), .pend(pend), .state(state), .ctl(ctl)
    );

    fwb_capture #(.MEM_AW(MEM_AW)) u_cap (
        .clk(clk), .rst(rst), .ctl(ctl), .bus_in(bus_in),
        .addr(mem_addr), .wbyte(mem_wdata)
    );

    fwb_memport #(.MEM_AW(MEM_AW), .BLOCK_W(BLOCK_W)) u_mem (
        .clk(clk), .rst(rst), .ctl(ctl), .addr(mem_addr),
        .top_lock(top_lock), .wr_protect(wr_protect),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .pend(pend), .mem_we(mem_we), .rbyte(rbyte)
    );

    fwb_drive u_drv (
        .state(state), .pend(pend), .rbyte(rbyte),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    assign mem_req = pend;

endmodule

// File: rtl/fwb_target_chk.sv
`timescale 1ns/1ps
module fwb_target_chk #(
    parameter int MEM_AW  = 19,
    parameter int BLOCK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic              bus_oe,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              top_lock,
    input logic              wr_protect
);

    logic addr_top;
    assign addr_top = &mem_addr[MEM_AW-1:BLOCK_W];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && frame_n) |=> mem_req); // R7

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> ($stable(mem_addr) && $stable(mem_we))); // R7

    AST_TOP_LOCK_VETO: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && mem_we) |-> !(addr_top && $past(top_lock))); // R8

    AST_PROTECT_VETO: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && mem_we) |-> !(!addr_top && $past(wr_protect))); // R9

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (!bus_oe && !mem_req)); // R10

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bus_oe && !mem_req)); // R11

endmodule

bind fwb_target fwb_target_chk #(.MEM_AW(MEM_AW), .BLOCK_W(BLOCK_W)) u_chk (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bus_oe(bus_oe),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .top_lock(top_lock), .wr_protect(wr_protect)
);

// File: tb/tb_fwb_target.sv
`timescale 1ns/1ps
module tb_fwb_target;

    localparam int         AW    = 19;
    localparam logic [3:0] STRAP = 4'hA;
    localparam logic [3:0] ONES  = 4'hF;

    typedef struct packed {
        logic        wr;
        logic [27:0] addr;
        logic [7:0]  wdata;
        logic [3:0]  lat;
        logic        tl;
        logic        wp;
        logic [3:0]  waits;
        logic        exp_wr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 28'h0012345, 8'h00, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{1'b0, 28'hABC7F0E, 8'h00, 4'd3, 1'b0, 1'b0, 4'd2, 1'b0},
        '{1'b1, 28'h0001020, 8'hA5, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        '{1'b1, 28'h0004444, 8'h3C, 4'd2, 1'b0, 1'b0, 4'd1, 1'b1},
        '{1'b1, 28'h0071234, 8'h77, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{1'b1, 28'h0071234, 8'h78, 4'd1, 1'b0, 1'b1, 4'd0, 1'b1},
        '{1'b1, 28'h0023456, 8'h11, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0},
        '{1'b1, 28'h0023456, 8'h22, 4'd4, 1'b1, 1'b0, 4'd3, 1'b1},
        '{1'b0, 28'h0075555, 8'h00, 4'd1, 1'b1, 1'b0, 4'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_n;
    logic [3:0]    bus_in;
    logic [3:0]    bus_out;
    logic          bus_oe;
    logic          top_lock;
    logic          wr_protect;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          mem_ready;

    always #10 clk = ~clk;

    fwb_target dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(STRAP),
        .top_lock(top_lock), .wr_protect(wr_protect),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    int lat = 0;
    int mcnt = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0]    last_data = '0;
    logic          s_oe;
    logic          s_req;
    logic [3:0]    s_out;

    // memory model: ready in the (lat+1)-th request cycle
    always @(negedge clk) begin
        mem_rdata = mem_addr[7:0] ^ 8'h5A;
        if (rst || !mem_req) begin
            mem_ready = 1'b0;
            mcnt      = 0;
        end else begin
            mem_ready = (mcnt == lat);
            if (mem_ready) begin
                if (mem_we) begin
                    wr_count++;
                    last_addr = mem_addr;
                    last_data = mem_wdata;
                end else begin
                    rd_count++;
                end
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R5 R6 act=%0d exp<=100000 cycles", cycles);
            report();
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic cyc(input logic f, input logic [3:0] n);
        @(negedge clk);
        s_oe    = bus_oe;
        s_out   = bus_out;
        s_req   = mem_req;
        frame_n = f;
        bus_in  = n;
    endtask

    task automatic hdr(input logic wr, input logic [3:0] id, input logic [27:0] a,
                       input logic [3:0] sz, output logic seen);
        seen = 1'b0;
        cyc(1'b0, wr ? 4'hE : 4'hD);
        cyc(1'b1, id);
        seen |= s_oe;
        for (int i = 6; i >= 0; i--) begin
            cyc(1'b1, a[i*4 +: 4]);
            seen |= s_oe;
        end
        cyc(1'b1, sz);
        seen |= s_oe;
    endtask

    task automatic quiet(input int n, output logic any_oe, output logic any_req);
        any_oe  = 1'b0;
        any_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, ONES);
            any_oe  |= s_oe;
            any_req |= s_req;
        end
    endtask

    task automatic run(input vec_t v);
        logic bad;
        logic ok;
        logic [7:0] d;
        int waits;
        int w0;
        top_lock   = v.tl;
        wr_protect = v.wp;
        lat        = int'(v.lat);
        w0         = wr_count;
        hdr(v.wr, STRAP, v.addr, 4'h0, bad);
        if (v.wr) begin
            cyc(1'b1, v.wdata[3:0]); bad |= s_oe;
            cyc(1'b1, v.wdata[7:4]); bad |= s_oe;
            cyc(1'b1, ONES);         bad |= s_oe;
            cyc(1'b1, ONES);         bad |= s_oe;
        end else begin
            cyc(1'b1, ONES); bad |= s_oe;
            cyc(1'b1, ONES); bad |= s_oe;
        end
        chk("R5 R6 target silent before sync", 32'(bad), 32'd0);
        waits = 0;
        cyc(1'b1, ONES);
        while (s_oe && s_out == 4'b0101 && waits < 40) begin
            waits++;
            cyc(1'b1, ONES);
        end
        chk("R5 R6 sync ready code", {s_oe, s_out}, {1'b1, 4'b0000});
        chk("R7 wait nibble count", 32'(waits), 32'(v.waits));
        if (!v.wr) begin
            cyc(1'b1, ONES); d[3:0] = s_out; ok = s_oe;
            cyc(1'b1, ONES); d[7:4] = s_out; ok &= s_oe;
            chk("R3 R5 read byte", {ok, d}, {1'b1, v.addr[7:0] ^ 8'h5A});
        end
        cyc(1'b1, ONES);
        chk("R5 closing ones", {s_oe, s_out}, {1'b1, 4'b1111});
        cyc(1'b1, ONES);
        chk("R5 bus released", 32'(s_oe), 32'd0);
        if (v.wr) begin
            chk("R8 R9 memory write issued", 32'(wr_count - w0), 32'(v.exp_wr));
            if (v.exp_wr) begin
                chk("R3 R6 write address", 32'(last_addr), 32'(v.addr[AW-1:0]));
                chk("R6 write byte", 32'(last_data), 32'(v.wdata));
            end
        end
        cyc(1'b1, ONES);
    endtask

    initial begin
        logic seen;
        logic qoe;
        logic qreq;
        int r0;
        rst        = 1'b1;
        frame_n    = 1'b1;
        bus_in     = ONES;
        top_lock   = 1'b0;
        wr_protect = 1'b0;
        mem_ready  = 1'b0;
        mem_rdata  = '0;
        repeat (3) @(negedge clk);
        chk("R11 quiet in reset", {bus_oe, mem_req}, 2'b00);
        rst = 1'b0;
        cyc(1'b1, ONES);
        chk("R11 quiet after reset", {s_oe, s_req}, 2'b00);

        for (int k = 0; k < NV; k++) run(VECS[k]);

        // R1: unknown start code, rest of a valid-looking header follows
        cyc(1'b0, 4'h3);
        cyc(1'b1, STRAP);
        for (int i = 0; i < 8; i++) cyc(1'b1, 4'h0);
        quiet(16, qoe, qreq);
        chk("R1 bad start ignored", {qoe, qreq}, 2'b00);

        // R2: select mismatch
        hdr(1'b0, STRAP ^ 4'h1, 28'h0012345, 4'h0, seen);
        quiet(16, qoe, qreq);
        chk("R2 other device ignored", {seen, qoe, qreq}, 3'b000);

        // R4: multi-byte size rejected
        hdr(1'b0, STRAP, 28'h0012345, 4'h1, seen);
        quiet(16, qoe, qreq);
        chk("R4 nonzero size ignored", {seen, qoe, qreq}, 3'b000);

        // R10: restart mid-address, then a full read
        r0 = rd_count;
        cyc(1'b0, 4'hD);
        cyc(1'b1, STRAP);
        cyc(1'b1, 4'h9);
        cyc(1'b1, 4'h9);
        run(VECS[0]);
        chk("R10 restart completes one read", 32'(rd_count - r0), 32'd1);

        // R10: abort while request waits
        r0  = rd_count;
        lat = 9;
        hdr(1'b0, STRAP, 28'h0033333, 4'h0, seen);
        for (int i = 0; i < 4; i++) cyc(1'b1, ONES);
        chk("R10 request pending before abort", 32'(s_req), 32'd1);
        cyc(1'b0, 4'h0);
        cyc(1'b1, ONES);
        chk("R10 abort withdraws", {s_oe, s_req}, 2'b00);
        quiet(12, qoe, qreq);
        chk("R10 stays idle after abort", {qoe, qreq, 32'(rd_count - r0)}, {2'b00, 32'd0});

        report();
    end

endmodule